// File: doc/BRIEF.md
# Receive Descriptor Ring Controller

This block is the device end of one receive queue whose buffer descriptors sit in a ring in host memory. Software hands empty buffers to the device by moving a write index forward. The controller takes descriptors in order, steers an incoming beat stream into the buffer it holds, and closes that buffer at frame end or when a close timer expires. On each close it writes the index of the filled descriptor to a status location and may raise an interrupt. The data movers are outside the block. A one-cycle descriptor read strobe stands in for one of them, and a per-beat fill strobe stands in for the other.

A five-state machine runs the channel. STOPPED is the parked state and drives the idle bit. STOPPED goes to ACQUIRE when the mode field selects normal operation. ACQUIRE goes to OPEN and pulses the descriptor read once the read index differs from the write index. OPEN goes to FILLING on the first beat of a buffer that does not end a frame, and goes to CLOSE on a single-beat frame. FILLING goes to CLOSE on a frame's last beat or on timer expiry. CLOSE lasts one cycle, publishes the status and returns to ACQUIRE, or to STOPPED when running is no longer allowed. ACQUIRE, OPEN and FILLING fall back to STOPPED when the mode forbids running. Running is allowed in normal mode, and in pause-at-frame-end mode only while a frame is unfinished.

Top module: `rx_ring_ctrl`

## Requirements
- R1: The ring holds 2^N descriptors. N is `cfg_ring_log2`, clamped to the range 5..12. The read index, the published index and the stored write index (the written value ANDed with 2^N-1) stay below 2^N, and the read index wraps from 2^N-1 to 0.
- R2: A write of `sw_widx` whose low three bits are zero replaces the write index. Any other value leaves the write index unchanged and sets an error flag, seen as `stat_word` bit 31, which stays set until reset.
- R3: A descriptor is taken (`desc_rd` high for one cycle, `desc_rd_idx` = read index) only when the read index differs from the write index. While the two are equal, `in_ready` stays low.
- R4: Closing a buffer gives a one-cycle `stat_wr` pulse in the next cycle. In that cycle `stat_word` bits 11:0 hold the index of the closed descriptor, and the read index moves on by one.
- R5: `cfg_run_mode` = 2'b10 runs the channel. 2'b00 or 2'b11 stops it at once. A buffer that is open is then dropped without being published, and the same descriptor is used again after restart.
- R6: `stat_word` bit 24 is high exactly while the channel is stopped, and `in_ready` is low while it is set.
- R7: The close timer starts when a buffer takes its first beat without the frame ending there. With `cfg_close_ticks` = T > 0, the buffer closes after T*TICK_DIV cycles in that state, and the rest of the frame goes into the next buffer. T = 0 turns the timer off.
- R8: `irq` pulses with `stat_wr` only when `cfg_irq_route` = 2'b01. Any other route gives no pulse.
- R9: With `cfg_run_mode` = 2'b01, the channel keeps running until the current frame's last beat has been written, including across a timer close. After that it stops and raises idle.
- R10: After reset the channel is stopped, both indexes are 0, and `stat_word` equals 32'h0100_0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_run_mode | input | 2 | 10 run, 01 pause at frame end, 00/11 stop |
| cfg_ring_log2 | input | 4 | Ring size exponent N |
| cfg_irq_route | input | 2 | 01 sends interrupts to host, else none |
| cfg_close_ticks | input | 8 | Close timeout in ticks, 0 disables |
| sw_widx_we | input | 1 | Software write-index update strobe |
| sw_widx | input | 12 | New write index |
| in_valid | input | 1 | Incoming beat present |
| in_last | input | 1 | Beat ends its frame |
| in_ready | output | 1 | Beat accepted when valid |
| desc_rd | output | 1 | Descriptor fetch strobe |
| desc_rd_idx | output | 12 | Descriptor to fetch |
| fill_we | output | 1 | Beat written into current buffer |
| fill_idx | output | 12 | Descriptor of current buffer |
| stat_wr | output | 1 | Status write strobe |
| stat_word | output | 32 | Status: [11:0] last closed, [24] idle, [31] error |
| irq | output | 1 | Host interrupt pulse |

## Verification
The case that is hardest to reach from the ports is a pause-at-frame-end request that arrives while a frame is spread over two buffers. To get there, the stimulus has to open a buffer with a non-final beat, hold the stream quiet until the close timer fires, switch the mode, and only then deliver the last beat. That sequence is driven with a small tick divider. The full-ring stall is reached by letting the read index run all the way around to an equal write index. A discarded buffer is reached by stopping in the middle of a frame and checking that the next frame reuses the same descriptor.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    typedef enum logic [2:0] {
        ST_STOPPED,
        ST_ACQUIRE,
        ST_OPEN,
        ST_FILLING,
        ST_CLOSE
    } rxr_state_e;

    localparam logic [1:0] MODE_STOP      = 2'b00;
    localparam logic [1:0] MODE_PAUSE_EOF = 2'b01;
    localparam logic [1:0] MODE_RUN       = 2'b10;

    localparam logic [1:0] ROUTE_HOST     = 2'b01;

    localparam int STAT_IDLE_BIT = 24;
    localparam int STAT_ERR_BIT  = 31;

endpackage

// File: rtl/rxr_ring_index.sv
module rxr_ring_index #(
    parameter int IDX_W   = 12,
    parameter int MIN_LOG = 5,
    parameter int MAX_LOG = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [3:0]       cfg_ring_log2,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_val,
    input  logic             advance,
    output logic [IDX_W-1:0] rd_idx,
    output logic [IDX_W-1:0] wr_idx,
    output logic [IDX_W-1:0] last_idx,
    output logic [IDX_W-1:0] ring_mask,
    output logic             room,
    output logic             err
);

    localparam int STEP_BITS = 3;

    logic [3:0]       eff_log;
    logic [IDX_W-1:0] rd_next;
    logic             step_ok;

    always_comb begin
        if (cfg_ring_log2 < 4'(MIN_LOG))
            eff_log = 4'(MIN_LOG);
        else if (cfg_ring_log2 > 4'(MAX_LOG))
            eff_log = 4'(MAX_LOG);
        else
            eff_log = cfg_ring_log2;
    end

    for (genvar gi = 0; gi < IDX_W; gi++) begin : g_mask
        assign ring_mask[gi] = (gi < int'(eff_log));
    end

    assign rd_next = (rd_idx + 1'b1) & ring_mask;
    assign step_ok = (sw_val[STEP_BITS-1:0] == '0);
    assign room    = (rd_idx != wr_idx);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_idx   <= '0;
            last_idx <= '0;
        end else if (advance) begin
            last_idx <= rd_idx;
            rd_idx   <= rd_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_idx <= '0;
            err    <= 1'b0;
        end else if (sw_we) begin
            if (step_ok)
                wr_idx <= sw_val & ring_mask;
            else
                err <= 1'b1;
        end
    end

endmodule

// File: rtl/rxr_close_timer.sv
module rxr_close_timer #(
    parameter int TICK_DIV = 3200,
    parameter int TO_W     = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic [TO_W-1:0] limit,
    output logic            expire
);

    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [TO_W-1:0]  tick_cnt;
    logic             tick;

    assign tick   = (pre_cnt == PRE_TOP);
    assign expire = run && (limit != '0) && tick && (tick_cnt == limit - 1'b1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (!run) begin
            pre_cnt  <= '0;
            tick_cnt <= '0;
        end else if (tick) begin
            pre_cnt  <= '0;
            tick_cnt <= tick_cnt + 1'b1;
        end else begin
            pre_cnt  <= pre_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/rxr_fsm.sv
module rxr_fsm
    import rxr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] run_mode,
    input  logic [1:0] irq_route,
    input  logic       room,
    input  logic       in_valid,
    input  logic       in_last,
    input  logic       expire,
    output rxr_state_e state,
    output logic       in_ready,
    output logic       desc_rd,
    output logic       fill_we,
    output logic       close_now,
    output logic       stat_wr,
    output logic       irq,
    output logic       idle
);

    rxr_state_e state_nx;
    logic       in_frame;
    logic       run_ok;
    logic       beat;
    logic       end_beat;

    assign run_ok = (run_mode == MODE_RUN) ||
                    ((run_mode == MODE_PAUSE_EOF) && in_frame);
    assign beat     = in_valid && in_ready;
    assign end_beat = beat && in_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_STOPPED;
        else
            state <= state_nx;
    end

    // frame tracking
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            in_frame <= 1'b0;
        else if (state_nx == ST_STOPPED)
            in_frame <= 1'b0;
        else if (beat)
            in_frame <= !in_last;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_STOPPED: begin
                if (run_mode == MODE_RUN)
                    state_nx = ST_ACQUIRE;
            end
            ST_ACQUIRE: begin
                if (!run_ok)
                    state_nx = ST_STOPPED;
                else if (room)
                    state_nx = ST_OPEN;
            end
            ST_OPEN: begin
                if (!run_ok)
                    state_nx = ST_STOPPED;
                else if (end_beat)
                    state_nx = ST_CLOSE;
                else if (beat)
                    state_nx = ST_FILLING;
            end
            ST_FILLING: begin
                if (!run_ok)
                    state_nx = ST_STOPPED;
                else if (end_beat || expire)
                    state_nx = ST_CLOSE;
            end
            ST_CLOSE: begin
                state_nx = run_ok ? ST_ACQUIRE : ST_STOPPED;
            end
            default: state_nx = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        in_ready  = 1'b0;
        desc_rd   = 1'b0;
        close_now = 1'b0;
        stat_wr   = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_STOPPED: idle = 1'b1;
            ST_ACQUIRE: desc_rd = run_ok && room;
            ST_OPEN: begin
                in_ready  = run_ok;
                close_now = run_ok && in_valid && in_last;
            end
            ST_FILLING: begin
                in_ready  = run_ok;
                close_now = run_ok && ((in_valid && in_last) || expire);
            end
            ST_CLOSE:   stat_wr = 1'b1;
            default:    idle = 1'b1;
        endcase
        fill_we = in_valid && in_ready;
        irq     = stat_wr && (irq_route == ROUTE_HOST);
    end

endmodule

// File: rtl/rx_ring_ctrl.sv
module rx_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int IDX_W    = 12,
    parameter int MIN_LOG  = 5,
    parameter int MAX_LOG  = 12,
    parameter int TO_W     = 8,
    parameter int TICK_DIV = 3200
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_run_mode,
    input  logic [3:0]       cfg_ring_log2,
    input  logic [1:0]       cfg_irq_route,
    input  logic [TO_W-1:0]  cfg_close_ticks,
    input  logic             sw_widx_we,
    input  logic [IDX_W-1:0] sw_widx,
    input  logic             in_valid,
    input  logic             in_last,
    output logic             in_ready,
    output logic             desc_rd,
    output logic [IDX_W-1:0] desc_rd_idx,
    output logic             fill_we,
    output logic [IDX_W-1:0] fill_idx,
    output logic             stat_wr,
    output logic [31:0]      stat_word,
    output logic             irq
);

    rxr_state_e       state;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] ring_mask;
    logic             room;
    logic             err;
    logic             expire;
    logic             close_now;
    logic             idle;

    rxr_ring_index #(
        .IDX_W   (IDX_W),
        .MIN_LOG (MIN_LOG),
        .MAX_LOG (MAX_LOG)
    ) u_index (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_ring_log2 (cfg_ring_log2),
        .sw_we         (sw_widx_we),
        .sw_val        (sw_widx),
        .advance       (close_now),
        .rd_idx        (rd_idx),
        .wr_idx        (wr_idx),
        .last_idx      (last_idx),
        .ring_mask     (ring_mask),
        .room          (room),
        .err           (err)
    );

    rxr_close_timer #(
        .TICK_DIV (TICK_DIV),
        .TO_W     (TO_W)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (state == ST_FILLING),
        .limit  (cfg_close_ticks),
        .expire (expire)
    );

    rxr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_mode  (cfg_run_mode),
        .irq_route (cfg_irq_route),
        .room      (room),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .expire    (expire),
        .state     (state),
        .in_ready  (in_ready),
        .desc_rd   (desc_rd),
        .fill_we   (fill_we),
        .close_now (close_now),
        .stat_wr   (stat_wr),
        .irq       (irq),
        .idle      (idle)
    );

    assign desc_rd_idx = rd_idx;
    assign fill_idx    = rd_idx;

    always_comb begin
        stat_word                = '0;
        stat_word[IDX_W-1:0]     = last_idx;
        stat_word[STAT_IDLE_BIT] = idle;
        stat_word[STAT_ERR_BIT]  = err;
    end

endmodule

// File: rtl/rx_ring_ctrl_chk.sv
module rx_ring_ctrl_chk #(
    parameter int IDX_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_ready,
    input logic             desc_rd,
    input logic [IDX_W-1:0] fill_idx,
    input logic             stat_wr,
    input logic [31:0]      stat_word,
    input logic             irq,
    input logic [IDX_W-1:0] rd_idx,
    input logic [IDX_W-1:0] wr_idx,
    input logic [IDX_W-1:0] ring_mask
);

    // R6
    idle_blocks_intake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[24] |-> !in_ready);

    // R3
    fetch_needs_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        desc_rd |-> (rd_idx != wr_idx));

    // R4
    publish_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |-> (stat_word[IDX_W-1:0] == $past(fill_idx)));

    // R4
    publish_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> !stat_wr);

    // R8
    irq_with_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> stat_wr);

    // R2
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[31] |=> stat_word[31]);

    // R1
    rd_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_idx & ~ring_mask) == '0);

endmodule

bind rx_ring_ctrl rx_ring_ctrl_chk #(.IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_ready  (in_ready),
    .desc_rd   (desc_rd),
    .fill_idx  (fill_idx),
    .stat_wr   (stat_wr),
    .stat_word (stat_word),
    .irq       (irq),
    .rd_idx    (rd_idx),
    .wr_idx    (wr_idx),
    .ring_mask (ring_mask)
);

// File: tb/rx_ring_ctrl_bench.sv
`timescale 1ns/1ps
module rx_ring_ctrl_bench;

    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_run_mode = 2'b00;
    logic [3:0]  cfg_ring_log2 = 4'd5;
    logic [1:0]  cfg_irq_route = 2'b01;
    logic [7:0]  cfg_close_ticks = 8'd0;
    logic        sw_widx_we = 1'b0;
    logic [11:0] sw_widx = '0;
    logic        in_valid = 1'b0;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic        desc_rd;
    logic [11:0] desc_rd_idx;
    logic        fill_we;
    logic [11:0] fill_idx;
    logic        stat_wr;
    logic [31:0] stat_word;
    logic        irq;

    int checks = 0;
    int failures = 0;
    int irq_seen = 0;
    bit done = 0;

    always #5 clk = ~clk;

    rx_ring_ctrl #(.TICK_DIV(DIV)) u_rx_ring_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_run_mode(cfg_run_mode),
        .cfg_ring_log2(cfg_ring_log2), .cfg_irq_route(cfg_irq_route),
        .cfg_close_ticks(cfg_close_ticks), .sw_widx_we(sw_widx_we),
        .sw_widx(sw_widx), .in_valid(in_valid), .in_last(in_last),
        .in_ready(in_ready), .desc_rd(desc_rd), .desc_rd_idx(desc_rd_idx),
        .fill_we(fill_we), .fill_idx(fill_idx), .stat_wr(stat_wr),
        .stat_word(stat_word), .irq(irq)
    );

    // behavioural reference: phase 0 parked, 1 waiting descriptor,
    // 2 buffer empty, 3 buffer partly filled, 4 publishing
    int m_ph, m_rd, m_wr, m_last, m_fillcyc;
    bit m_err, m_mid, m_took;

    function automatic int ring_size();
        int n = int'(cfg_ring_log2);
        if (n < 5) n = 5;
        if (n > 12) n = 12;
        return 1 << n;
    endfunction

    function automatic bit may_run();
        return (cfg_run_mode == 2'b10) || (cfg_run_mode == 2'b01 && m_mid);
    endfunction

    function automatic bit exp_ready();
        return (m_ph == 2 || m_ph == 3) && may_run();
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_rd = 0; m_wr = 0; m_last = 0; m_fillcyc = 0;
            m_err = 0; m_mid = 0; m_took = 0;
        end else begin
            bit go, take, shut;
            go = may_run();
            take = in_valid && exp_ready();
            shut = 0;
            m_took = take;
            case (m_ph)
                0: if (cfg_run_mode == 2'b10) m_ph = 1;
                1: if (!go) m_ph = 0; else if (m_rd != m_wr) m_ph = 2;
                2: if (!go) m_ph = 0;
                   else if (take) begin
                       m_mid = !in_last;
                       if (in_last) shut = 1;
                       else begin m_ph = 3; m_fillcyc = 0; end
                   end
                3: if (!go) m_ph = 0;
                   else if (take && in_last) begin m_mid = 0; shut = 1; end
                   else if (cfg_close_ticks != 0 &&
                            m_fillcyc + 1 == int'(cfg_close_ticks) * DIV) shut = 1;
                   else m_fillcyc++;
                4: m_ph = go ? 1 : 0;
                default: m_ph = 0;
            endcase
            if (shut) begin
                m_last = m_rd;
                m_rd = (m_rd + 1) % ring_size();
                m_ph = 4;
            end
            if (m_ph == 0) m_mid = 0;
            if (sw_widx_we) begin
                if (sw_widx % 8 != 0) m_err = 1;
                else m_wr = int'(sw_widx) % ring_size();
            end
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            bit e_idle, e_rdy;
            longint e_word;
            e_idle = (m_ph == 0);
            e_rdy = exp_ready();
            e_word = (longint'(m_err) << 31) | (longint'(e_idle) << 24) | m_last;
            chk(stat_word[24] == e_idle, "R6 idle", stat_word[24], e_idle);
            chk(in_ready == e_rdy, "R3 in_ready", in_ready, e_rdy);
            chk(desc_rd == (m_ph == 1 && may_run() && m_rd != m_wr), "R3 desc_rd",
                desc_rd, (m_ph == 1 && may_run() && m_rd != m_wr));
            chk(desc_rd_idx == 12'(m_rd), "R1 desc_rd_idx", desc_rd_idx, m_rd);
            chk(fill_idx == 12'(m_rd), "R1 fill_idx", fill_idx, m_rd);
            chk(fill_we == (in_valid && e_rdy), "R4 fill_we", fill_we, in_valid && e_rdy);
            chk(stat_wr == (m_ph == 4), "R4 stat_wr", stat_wr, m_ph == 4);
            chk(irq == (m_ph == 4 && cfg_irq_route == 2'b01), "R8 irq", irq,
                (m_ph == 4 && cfg_irq_route == 2'b01));
            chk(stat_word == 32'(e_word), "R4 R2 stat_word", stat_word, e_word);
            if (irq) irq_seen++;
        end
    end

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_widx(input int v);
        @(negedge clk);
        sw_widx_we = 1'b1; sw_widx = 12'(v);
        @(negedge clk);
        sw_widx_we = 1'b0;
    endtask

    task automatic beat(input bit last);
        @(negedge clk);
        in_valid = 1'b1; in_last = last;
        for (int k = 0; k < 200; k++) begin
            @(negedge clk);
            if (m_took) break;
        end
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic frames(input int count);
        for (int f = 0; f < count; f++) beat(1'b1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int irq_before;
        idle_for(3);
        rst_n = 1'b1;
        idle_for(2);
        // R10 reset state
        chk(stat_word == 32'h0100_0000, "R10 reset word", stat_word, 32'h0100_0000);
        chk(in_ready == 1'b0, "R10 reset ready", in_ready, 0);

        put_widx(8);
        cfg_run_mode = 2'b10;
        frames(3);
        idle_for(3);
        chk(stat_word == 32'h2, "R4 three frames", stat_word, 32'h2);
        beat(1'b0); beat(1'b1);
        frames(4);
        idle_for(4);
        // R3 ring full at rd == wr == 8
        chk(stat_word == 32'h7, "R3 full stop index", stat_word, 32'h7);
        chk(in_ready == 1'b0, "R3 full no intake", in_ready, 0);

        put_widx(13);
        idle_for(2);
        chk(stat_word == 32'h8000_0007, "R2 bad step", stat_word, 32'h8000_0007);
        chk(in_ready == 1'b0, "R2 index unchanged", in_ready, 0);

        put_widx(0);
        frames(24);
        idle_for(4);
        chk(stat_word[11:0] == 12'd31, "R1 last before wrap", stat_word[11:0], 31);
        chk(in_ready == 1'b0, "R1 full after wrap", in_ready, 0);
        put_widx(8);
        frames(1);
        idle_for(3);
        chk(stat_word[11:0] == 12'd0, "R1 wrapped index", stat_word[11:0], 0);

        // R7 timer close, frame continues in next buffer
        cfg_close_ticks = 8'd3;
        put_widx(16);
        irq_before = irq_seen;
        beat(1'b0);
        idle_for(20);
        chk(stat_word[11:0] == 12'd1, "R7 timeout close", stat_word[11:0], 1);
        chk(irq_seen == irq_before + 1, "R8 irq on timeout", irq_seen, irq_before + 1);
        beat(1'b1);
        idle_for(3);
        chk(stat_word[11:0] == 12'd2, "R7 continuation", stat_word[11:0], 2);

        // R8 route none
        cfg_irq_route = 2'b00;
        irq_before = irq_seen;
        frames(1);
        idle_for(3);
        chk(irq_seen == irq_before, "R8 no irq", irq_seen, irq_before);
        chk(stat_word[11:0] == 12'd3, "R8 still published", stat_word[11:0], 3);
        cfg_irq_route = 2'b01;

        // R9 pause at frame end across a timer close
        beat(1'b0);
        cfg_run_mode = 2'b01;
        idle_for(20);
        chk(stat_word == 32'h8000_0004, "R9 running mid-frame", stat_word, 32'h8000_0004);
        beat(1'b1);
        idle_for(3);
        chk(stat_word == 32'h8100_0005, "R9 idle after end", stat_word, 32'h8100_0005);

        // R5 stop mid-frame drops the buffer
        cfg_close_ticks = 8'd0;
        cfg_run_mode = 2'b10;
        beat(1'b0);
        cfg_run_mode = 2'b00;
        idle_for(3);
        chk(stat_word == 32'h8100_0005, "R5 stop drops", stat_word, 32'h8100_0005);
        cfg_run_mode = 2'b10;
        frames(1);
        idle_for(3);
        chk(stat_word[11:0] == 12'd6, "R5 descriptor reused", stat_word[11:0], 6);

        // R1 clamp: exponent 2 acts as 5, write 40 masks to 8
        cfg_run_mode = 2'b00;
        cfg_ring_log2 = 4'd2;
        put_widx(40);
        cfg_run_mode = 2'b10;
        frames(1);
        idle_for(4);
        chk(stat_word[11:0] == 12'd7, "R1 clamp index", stat_word[11:0], 7);
        chk(in_ready == 1'b0, "R1 clamp full", in_ready, 0);

        idle_for(5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule